// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer that brings a step-down converter up gently and recovers it from faults. A counter holds a code that stands for the soft-start capacitor voltage, at one code per millivolt. While nothing is wrong the counter charges in large steps and is clamped at a ceiling. Several thresholds on that one level decide three things: when the regulation reference starts to rise, when the power switches may begin to pulse, and when the fast window loop is allowed to act.

Three conditions set a set-dominant fault latch: the enable bit going low, the supply code falling into lockout, or an overcurrent bit that has stayed high through a digital filter. While the latch is set, both drivers stay off. A disable or a lockout also pulls the level to zero at once. An overcurrent fault leaves the level to finish its charge and then drains it in small steps, ten times slower than the charge. The latch clears only near the bottom of the drain, and only if no fault source is still active, which starts a fresh soft start. The slow drain sets the hiccup off-time.

Top module: `hiccup_seq`

## Requirements
- R1: While rst_n is low, fault_o is 1, ref_o is 0, sw_en_o is 0 and win_en_o is 0. The internal level is 0 and the supply is treated as not good.
- R2: With en_i high, the supply good and no filtered overcurrent, the fault latch clears. The level then rises by 10 codes per clock and saturates at 2400.
- R3: ref_o is 0 while the level is at or below 300. Above 300 it is the level minus 300, capped at 1250.
- R4: sw_en_o is 1 exactly when the fault latch is clear and the level is at least 700.
- R5: win_en_o is 1 exactly when the fault latch is clear and the level is at least 2000.
- R6: The supply is judged good, one clock after sampling, once vcc_i (in mV) is at least 2850. It is judged bad once vcc_i is below 2750. Between those values it keeps its last judgement. A bad supply sets the fault latch and forces the level to 0.
- R7: en_i low sets the fault latch and forces the level to 0 on the next clock, so ref_o, sw_en_o and win_en_o are all 0.
- R8: oc_raw_i counts as a fault only after it has been high for 16 consecutive clocks. Any low cycle restarts the count.
- R9: An overcurrent fault during the ramp sets the latch at once. The level keeps charging to 2400 and then drains. The drivers stay off throughout.
- R10: While draining, the level falls by 1 code per clock. When the level is at or below 250 and no fault source is active, the latch clears and a new charge begins.
- R11: The latch is set-dominant. If a fault source is still active when the drain reaches 250, the latch stays set, the level falls to 0 and holds there until the source goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable, already resolved to a logic level |
| vcc_i | input | 12 | Supply voltage code in mV |
| oc_raw_i | input | 1 | Unfiltered overcurrent comparator bit |
| fault_o | output | 1 | Fault latch state |
| ref_o | output | 12 | Ramped reference code in mV |
| sw_en_o | output | 1 | Switching allowed |
| win_en_o | output | 1 | Window loop enable |

## Verification
A clean start-up ramp is tried with the bench stopping at chosen cycle counts. Each stop tells the reference offset, the switching threshold, the window threshold and the clamp apart. Overcurrent pulses of 15 and 17 clocks separate a filter that restarts on a gap from one that saturates or counts the wrong length. A fault taken mid-ramp and one taken at the clamp show whether the charge finishes before the drain. An overcurrent held through the whole drain, and supply codes between the two lockout levels, show set-dominance and hysteresis as opposed to a plain threshold.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    // Direction the soft-start level is moving in.
    typedef enum logic {
        PH_CHARGE = 1'b0,
        PH_DRAIN  = 1'b1
    } ssq_phase_e;

endpackage

// File: rtl/ssq_hyst.sv
// Supply lockout comparator with hysteresis, registered.
module ssq_hyst #(
    parameter int VCC_W  = 12,
    parameter int ON_MV  = 2850,
    parameter int OFF_MV = 2750
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VCC_W-1:0] vcc_i,
    output logic             ok_o
);
    localparam logic [VCC_W-1:0] ON_C  = VCC_W'(ON_MV);
    localparam logic [VCC_W-1:0] OFF_C = VCC_W'(OFF_MV);

    logic ok_d, ok_q;

    always_comb begin
        if (ok_q) ok_d = (vcc_i >= OFF_C);
        else      ok_d = (vcc_i >= ON_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= ok_d;
    end

    assign ok_o = ok_q;
endmodule

// File: rtl/ssq_ocfilt.sv
// Persistence filter for the raw overcurrent bit.
module ssq_ocfilt #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FILT_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!raw_i)             cnt_d = '0;
        else if (cnt_q == FULL) cnt_d = FULL;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = (cnt_q == FULL);
endmodule

// File: rtl/ssq_decode.sv
// Threshold decode of the soft-start level.
module ssq_decode #(
    parameter int LVL_W   = 12,
    parameter int REF_OFS = 300,
    parameter int REF_MAX = 1250,
    parameter int SW_LVL  = 700,
    parameter int WIN_LVL = 2000,
    parameter int CLAMP   = 2400,
    parameter int RST_LVL = 250
) (
    input  logic [LVL_W-1:0] lvl_i,
    output logic [LVL_W-1:0] ref_o,
    output logic             above_sw_o,
    output logic             above_win_o,
    output logic             at_clamp_o,
    output logic             at_bottom_o
);
    localparam logic [LVL_W-1:0] OFS_C = LVL_W'(REF_OFS);
    localparam logic [LVL_W-1:0] MAX_C = LVL_W'(REF_MAX);
    localparam logic [LVL_W-1:0] SW_C  = LVL_W'(SW_LVL);
    localparam logic [LVL_W-1:0] WIN_C = LVL_W'(WIN_LVL);
    localparam logic [LVL_W-1:0] CLP_C = LVL_W'(CLAMP);
    localparam logic [LVL_W-1:0] BOT_C = LVL_W'(RST_LVL);

    logic [LVL_W-1:0] diff;

    always_comb begin
        diff = lvl_i - OFS_C;
        if (lvl_i <= OFS_C)     ref_o = '0;
        else if (diff > MAX_C)  ref_o = MAX_C;
        else                    ref_o = diff;
    end

    assign above_sw_o  = (lvl_i >= SW_C);
    assign above_win_o = (lvl_i >= WIN_C);
    assign at_clamp_o  = (lvl_i >= CLP_C);
    assign at_bottom_o = (lvl_i <= BOT_C);
endmodule

// File: rtl/hiccup_seq.sv
// Soft-start ramp and hiccup fault recovery sequencer.
module hiccup_seq #(
    parameter int LVL_W    = 12,
    parameter int VCC_W    = 12,
    parameter int CHG_STEP = 10,
    parameter int DIS_STEP = 1,
    parameter int CLAMP    = 2400,
    parameter int REF_OFS  = 300,
    parameter int REF_MAX  = 1250,
    parameter int SW_LVL   = 700,
    parameter int WIN_LVL  = 2000,
    parameter int RST_LVL  = 250,
    parameter int UV_ON    = 2850,
    parameter int UV_OFF   = 2750,
    parameter int OC_FILT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [VCC_W-1:0] vcc_i,
    input  logic             oc_raw_i,
    output logic             fault_o,
    output logic [LVL_W-1:0] ref_o,
    output logic             sw_en_o,
    output logic             win_en_o
);
    import ssq_pkg::*;

    localparam logic [LVL_W:0]   CHG_C = (LVL_W+1)'(CHG_STEP);
    localparam logic [LVL_W:0]   CLP_W = (LVL_W+1)'(CLAMP);
    localparam logic [LVL_W-1:0] CLP_C = LVL_W'(CLAMP);
    localparam logic [LVL_W-1:0] DIS_C = LVL_W'(DIS_STEP);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        ssq_phase_e       ph;
        logic             fault;
    } core_t;

    core_t cur_d, cur_q;

    logic             supply_ok;
    logic             oc_hit;
    logic [LVL_W-1:0] lvl_q;
    logic             above_sw, above_win, at_clamp, at_bottom;
    logic             hold, fault_set, drain_done;
    logic [LVL_W:0]   sum_w;

    assign lvl_q = cur_q.lvl;

    ssq_hyst #(
        .VCC_W (VCC_W),
        .ON_MV (UV_ON),
        .OFF_MV(UV_OFF)
    ) u_uvlo (
        .clk  (clk),
        .rst_n(rst_n),
        .vcc_i(vcc_i),
        .ok_o (supply_ok)
    );

    ssq_ocfilt #(
        .FILT_CYC(OC_FILT)
    ) u_ocf (
        .clk  (clk),
        .rst_n(rst_n),
        .raw_i(oc_raw_i),
        .hit_o(oc_hit)
    );

    ssq_decode #(
        .LVL_W  (LVL_W),
        .REF_OFS(REF_OFS),
        .REF_MAX(REF_MAX),
        .SW_LVL (SW_LVL),
        .WIN_LVL(WIN_LVL),
        .CLAMP  (CLAMP),
        .RST_LVL(RST_LVL)
    ) u_dec (
        .lvl_i      (lvl_q),
        .ref_o      (ref_o),
        .above_sw_o (above_sw),
        .above_win_o(above_win),
        .at_clamp_o (at_clamp),
        .at_bottom_o(at_bottom)
    );

    always_comb begin
        cur_d      = cur_q;
        hold       = !en_i || !supply_ok;
        fault_set  = hold || oc_hit;
        drain_done = cur_q.fault && (cur_q.ph == PH_DRAIN) && at_bottom && !fault_set;
        sum_w      = {1'b0, cur_q.lvl} + CHG_C;

        if (hold) begin
            cur_d.lvl = '0;
            cur_d.ph  = PH_DRAIN;
        end else if (cur_q.ph == PH_CHARGE) begin
            if (sum_w >= CLP_W) cur_d.lvl = CLP_C;
            else                cur_d.lvl = sum_w[LVL_W-1:0];
            if (cur_q.fault && at_clamp) cur_d.ph = PH_DRAIN;
        end else begin
            if (cur_q.lvl >= DIS_C) cur_d.lvl = cur_q.lvl - DIS_C;
            else                    cur_d.lvl = '0;
        end

        if (drain_done) cur_d.ph = PH_CHARGE;

        // set wins over clear
        cur_d.fault = fault_set || (cur_q.fault && !drain_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.lvl   <= '0;
            cur_q.ph    <= PH_DRAIN;
            cur_q.fault <= 1'b1;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign fault_o  = cur_q.fault;
    assign sw_en_o  = !cur_q.fault && above_sw;
    assign win_en_o = !cur_q.fault && above_win;
endmodule

// File: rtl/hiccup_chk.sv
// Property checker for the soft-start and hiccup sequencer.
module hiccup_chk #(
    parameter int LVL_W    = 12,
    parameter int CHG_STEP = 10,
    parameter int DIS_STEP = 1,
    parameter int CLAMP    = 2400,
    parameter int RST_LVL  = 250
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             supply_ok,
    input logic             oc_hit,
    input logic             fault_o,
    input logic             sw_en_o,
    input logic             win_en_o,
    input logic [LVL_W-1:0] lvl_q,
    input logic [LVL_W-1:0] ref_o
);
    localparam logic [LVL_W:0]   CHG_W = (LVL_W+1)'(CHG_STEP);
    localparam logic [LVL_W:0]   DIS_W = (LVL_W+1)'(DIS_STEP);
    localparam logic [LVL_W-1:0] CLP_C = LVL_W'(CLAMP);
    localparam logic [LVL_W-1:0] BOT_C = LVL_W'(RST_LVL);

    // R7: a disable faults and empties the level on the next clock
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (fault_o && ref_o == '0));

    // R6: a bad supply judgement sets the latch
    a_r6_lockout_faults: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> fault_o);

    // R11: a filtered overcurrent always sets the latch
    a_r11_set_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        oc_hit |=> fault_o);

    // R2: the level never rises faster than one charge step
    a_r2_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, lvl_q} <= {1'b0, $past(lvl_q)} + CHG_W));

    // R10: a fall is one drain step or a forced return to zero
    a_r10_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_q >= $past(lvl_q) || lvl_q == '0 ||
                  ({1'b0, lvl_q} + DIS_W) == {1'b0, $past(lvl_q)}));

    // R9: a set latch cannot clear above the restart level
    a_r9_no_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && lvl_q > BOT_C && lvl_q < CLP_C) |=> fault_o);

    // R5: the window loop implies switching is allowed
    a_r5_win_needs_sw: assert property (@(posedge clk) disable iff (!rst_n)
        win_en_o |-> sw_en_o);
endmodule

bind hiccup_seq hiccup_chk #(
    .LVL_W   (LVL_W),
    .CHG_STEP(CHG_STEP),
    .DIS_STEP(DIS_STEP),
    .CLAMP   (CLAMP),
    .RST_LVL (RST_LVL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .supply_ok(supply_ok),
    .oc_hit   (oc_hit),
    .fault_o  (fault_o),
    .sw_en_o  (sw_en_o),
    .win_en_o (win_en_o),
    .lvl_q    (lvl_q),
    .ref_o    (ref_o)
);

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;
    localparam int CLK_PERIOD = 10;

    // values taken from the requirements
    localparam int CHG = 10, DIS = 1, CLP = 2400, OFS = 300, RMAX = 1250;
    localparam int SWL = 700, WINL = 2000, BOT = 250, VON = 2850, VOFF = 2750, FILT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [11:0] vcc_i = '0;
    logic        oc_raw_i = 1'b0;
    logic        fault_o, sw_en_o, win_en_o;
    logic [11:0] ref_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model state
    int m_lvl, m_fl, m_dr, m_ok, m_oc;

    logic [14:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hiccup_seq i_hiccup_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .vcc_i   (vcc_i),
        .oc_raw_i(oc_raw_i),
        .fault_o (fault_o),
        .ref_o   (ref_o),
        .sw_en_o (sw_en_o),
        .win_en_o(win_en_o)
    );

    function automatic logic [14:0] model_out();
        int r;
        logic f, s, w;
        if (m_lvl <= OFS) r = 0;
        else if (m_lvl - OFS > RMAX) r = RMAX;
        else r = m_lvl - OFS;
        f = (m_fl != 0);
        s = !f && (m_lvl >= SWL);
        w = !f && (m_lvl >= WINL);
        return {f, s, w, 12'(r)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input logic en, input int vcc, input logic oc, input string tag);
        int  n_lvl, n_dr, n_ok, n_oc;
        bit  hold, fset, rel;
        @(negedge clk);
        en_i = en; vcc_i = 12'(vcc); oc_raw_i = oc;
        hold = !en || (m_ok == 0);
        fset = hold || (m_oc == FILT);
        rel  = (m_fl != 0) && (m_dr != 0) && (m_lvl <= BOT) && !fset;
        n_dr = m_dr;
        if (hold) begin
            n_lvl = 0; n_dr = 1;
        end else if (m_dr == 0) begin
            n_lvl = (m_lvl + CHG >= CLP) ? CLP : m_lvl + CHG;
            if (m_fl != 0 && m_lvl >= CLP) n_dr = 1;
        end else begin
            n_lvl = (m_lvl >= DIS) ? m_lvl - DIS : 0;
        end
        if (rel) n_dr = 0;
        m_fl  = (fset || (m_fl != 0 && !rel)) ? 1 : 0;
        n_ok  = (m_ok != 0) ? int'(vcc >= VOFF) : int'(vcc >= VON);
        n_oc  = !oc ? 0 : ((m_oc == FILT) ? FILT : m_oc + 1);
        m_lvl = n_lvl; m_dr = n_dr; m_ok = n_ok; m_oc = n_oc;
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input logic en, input int vcc, input logic oc, input string tag);
        for (int i = 0; i < n; i++) step(en, vcc, oc, tag);
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    // monitor: pops one expectation per clock and compares
    always begin
        logic [14:0] e;
        string t;
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({fault_o, sw_en_o, win_en_o, ref_o} !== e) begin
                bad++;
                $display("FAIL %s: actual f=%0d sw=%0d win=%0d ref=%0d expected f=%0d sw=%0d win=%0d ref=%0d",
                         t, fault_o, sw_en_o, win_en_o, ref_o, e[14], e[13], e[12], e[11:0]);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_lvl = 0; m_fl = 1; m_dr = 1; m_ok = 0; m_oc = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 fault", int'(fault_o), 1);
        chk("R1 ref", int'(ref_o), 0);
        chk("R1 sw", int'(sw_en_o), 0);
        chk("R1 win", int'(win_en_o), 0);
        rst_n = 1'b1;

        // R2/R3/R4/R5 clean ramp
        run(52, 1'b1, 3300, 1'b0, "R2 ramp");
        settle();
        chk("R3 ref at 500", int'(ref_o), 200);
        chk("R4 sw below 700", int'(sw_en_o), 0);
        chk("R2 fault cleared", int'(fault_o), 0);
        run(20, 1'b1, 3300, 1'b0, "R4 ramp");
        settle();
        chk("R4 sw at 700", int'(sw_en_o), 1);
        chk("R5 win below 2000", int'(win_en_o), 0);
        run(130, 1'b1, 3300, 1'b0, "R5 ramp");
        settle();
        chk("R5 win at 2000", int'(win_en_o), 1);
        run(100, 1'b1, 3300, 1'b0, "R2 clamp");
        settle();
        chk("R3 ref capped", int'(ref_o), 1250);

        // R8 filter restart and expiry
        run(15, 1'b1, 3300, 1'b1, "R8 short");
        run(1,  1'b1, 3300, 1'b0, "R8 gap");
        run(15, 1'b1, 3300, 1'b1, "R8 short");
        run(1,  1'b1, 3300, 1'b0, "R8 gap");
        settle();
        chk("R8 no fault after gaps", int'(fault_o), 0);
        chk("R8 sw kept", int'(sw_en_o), 1);
        run(17, 1'b1, 3300, 1'b1, "R8 long");
        settle();
        chk("R8 fault after 16", int'(fault_o), 1);
        chk("R8 sw off", int'(sw_en_o), 0);

        // R10 drain and restart
        run(1000, 1'b1, 3300, 1'b0, "R10 drain");
        settle();
        chk("R10 ref while draining", int'(ref_o), 1101);
        chk("R10 fault held", int'(fault_o), 1);
        run(2000, 1'b1, 3300, 1'b0, "R10 restart");
        settle();
        chk("R10 fault cleared", int'(fault_o), 0);
        chk("R10 sw back", int'(sw_en_o), 1);

        // R7 disable, then R9 fault mid-ramp
        run(1, 1'b0, 3300, 1'b0, "R7 disable");
        settle();
        chk("R7 fault", int'(fault_o), 1);
        chk("R7 ref", int'(ref_o), 0);
        run(100, 1'b1, 3300, 1'b0, "R9 ramp");
        run(17, 1'b1, 3300, 1'b1, "R9 oc");
        run(30, 1'b1, 3300, 1'b0, "R9 charge on");
        settle();
        chk("R9 fault", int'(fault_o), 1);
        chk("R9 sw off", int'(sw_en_o), 0);
        chk("R9 level still rising", int'(ref_o), 1160);
        run(3000, 1'b1, 3300, 1'b0, "R9 recover");
        settle();
        chk("R9 recovered", int'(fault_o), 0);

        // R11 fault held through the whole drain
        run(3017, 1'b1, 3300, 1'b1, "R11 held");
        settle();
        chk("R11 fault kept", int'(fault_o), 1);
        chk("R11 level at zero", int'(ref_o), 0);
        run(300, 1'b1, 3300, 1'b0, "R11 release");
        settle();
        chk("R11 restarted", int'(sw_en_o), 1);

        // R6 lockout hysteresis
        run(10, 1'b1, 2800, 1'b0, "R6 inside band");
        settle();
        chk("R6 still good", int'(fault_o), 0);
        run(5, 1'b1, 2700, 1'b0, "R6 low");
        settle();
        chk("R6 lockout fault", int'(fault_o), 1);
        chk("R6 lockout ref", int'(ref_o), 0);
        run(20, 1'b1, 2800, 1'b0, "R6 band from low");
        settle();
        chk("R6 still locked", int'(fault_o), 1);
        run(300, 1'b1, 2850, 1'b0, "R6 recover");
        settle();
        chk("R6 recovered", int'(win_en_o), 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule